// File: doc/BRIEF.md
# Adaptive Threshold QRS Detector

This block watches a stream of signed derivative samples taken from an ECG signal that has already been filtered. It reports each QRS complex as a one-cycle beat pulse. A sample can only count as a beat while the detector is armed, and only if its magnitude is strictly above a threshold that adapts over time. Each beat opens a measurement window. While that window is open no further beat can be reported, and the block records the largest magnitude it sees. When the window closes, the threshold is re-seeded at three quarters of that peak. From then on the threshold falls by a fixed step on every sample until it reaches a floor.

A short guard window follows the measurement window. If a sample rises above the threshold inside the guard window, the block treats it as noise. It raises the threshold by a fixed step, pulses a noise flag, and pulses an interval-restart output. The restart tells downstream R-R timing to discard the interval in progress and start it again. All time is counted in valid samples. The window lengths come from the sample rate parameter: at the default 500 samples per second they are 100 samples (200 ms) and 120 samples (240 ms).

Top module: `qrs_thresh_detector`

## Requirements
- R1: A valid sample taken while armed produces `beat_pulse` high for exactly one cycle, in the cycle after the sample's clock edge, when its magnitude is strictly greater than the threshold. A magnitude equal to the threshold gives no beat.
- R2: During the MEAS_TICKS valid samples that follow a beat, no beat is reported, whatever their magnitude.
- R3: On the last sample of the measurement window, the threshold becomes P − (P >> 2). P is the largest magnitude among the beat sample and the window samples. The result is clamped to the range [THR_FLOOR, THR_CEIL]. The threshold does not change inside the measurement window.
- R4: On every valid sample in the guard window or in the armed state that is neither a beat nor noise, the threshold falls by DECAY_STEP. It never drops below THR_FLOOR.
- R5: The guard window covers valid samples MEAS_TICKS+1 through GUARD_TICKS after a beat. A sample in it whose magnitude is strictly above the threshold pulses `noise_flag` and `interval_restart` for one cycle, and no beat is reported for it.
- R6: On noise, the threshold rises by NOISE_STEP, saturating at THR_CEIL, and the detector re-arms from the next sample.
- R7: Magnitude is the absolute value of the 16-bit two's complement sample. The code 0x8000 maps to 32767.
- R8: Synchronous active-high reset sets the threshold to THR_FLOOR, arms the detector and clears all outputs. This holds even in the middle of a window.
- R9: Cycles with `smp_valid` low advance no window and change no state. The cycle after such a cycle carries no beat and no noise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe, one per sample period |
| smp_data | input | SAMPLE_W | Signed derivative sample |
| beat_pulse | output | 1 | One-cycle QRS detection pulse |
| noise_flag | output | 1 | One-cycle noise indication in the guard window |
| interval_restart | output | 1 | One-cycle request to restart the current R-R interval |

## Verification
The bench builds the block with SAMPLE_RATE = 50, so the measurement and guard windows are 10 and 12 samples long. At that size a whole beat–measure–guard cycle fits in a short vector table. The floor and ceiling are kept at 900 and 1320. The bench uses larger steps, DECAY_STEP = 10 and NOISE_STEP = 100. This lets a few dozen samples carry the threshold from the ceiling back down to the floor, and lets one noise event reach the ceiling saturation. With these values the clamp at both ends, the strict comparison, and the 0x8000 magnitude can all be reached with hand-computed expected values.

// File: rtl/qrs_pkg.sv
package qrs_pkg;

    typedef enum logic [1:0] {
        PH_ARMED = 2'd0,
        PH_MEAS  = 2'd1,
        PH_GUARD = 2'd2
    } qrs_phase_e;

    typedef struct packed {
        logic beat;
        logic noise;
    } qrs_event_t;

    function automatic int unsigned ticks_for_ms(input int unsigned rate_hz,
                                                 input int unsigned span_ms);
        return (rate_hz * span_ms) / 1000;
    endfunction

endpackage

// File: rtl/qrs_magnitude.sv
module qrs_magnitude #(
    parameter int SAMPLE_W = 16,
    localparam int MAG_W   = SAMPLE_W - 1
) (
    input  logic signed [SAMPLE_W-1:0] smp,
    output logic        [MAG_W-1:0]    mag
);
    logic [SAMPLE_W-1:0] negated;
    logic                most_neg;

    always_comb begin
        negated  = (~smp) + 1'b1;
        most_neg = (smp == {1'b1, {MAG_W{1'b0}}});
        if (!smp[SAMPLE_W-1])
            mag = smp[MAG_W-1:0];
        else if (most_neg)
            mag = {MAG_W{1'b1}};
        else
            mag = negated[MAG_W-1:0];
    end
endmodule

// File: rtl/qrs_window_timer.sv
module qrs_window_timer
    import qrs_pkg::*;
#(
    parameter int MEAS_TICKS  = 100,
    parameter int GUARD_TICKS = 120,
    localparam int CNT_W      = $clog2(GUARD_TICKS + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       smp_valid,
    input  logic       beat_hit,
    input  logic       noise_hit,
    output qrs_phase_e phase,
    output logic       meas_last
);
    localparam logic [CNT_W-1:0] MEAS_END  = CNT_W'(MEAS_TICKS - 1);
    localparam logic [CNT_W-1:0] GUARD_END = CNT_W'(GUARD_TICKS - 1);

    logic [CNT_W-1:0] cnt;

    assign meas_last = smp_valid && (phase == PH_MEAS) && (cnt == MEAS_END);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_ARMED;
            cnt   <= '0;
        end else begin
            unique case (phase)
                PH_ARMED: begin
                    if (beat_hit) begin
                        phase <= PH_MEAS;
                        cnt   <= '0;
                    end
                end
                PH_MEAS: begin
                    if (smp_valid) begin
                        cnt <= cnt + 1'b1;
                        if (meas_last)
                            phase <= PH_GUARD;
                    end
                end
                PH_GUARD: begin
                    if (smp_valid) begin
                        cnt <= cnt + 1'b1;
                        if (noise_hit || (cnt == GUARD_END))
                            phase <= PH_ARMED;
                    end
                end
                default: phase <= PH_ARMED;
            endcase
        end
    end

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!smp_valid && phase != PH_ARMED) |=> $stable(cnt));

    // R2
    meas_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_ARMED && beat_hit) |=> (phase == PH_MEAS && cnt == '0));
endmodule

// File: rtl/qrs_thresh_ctrl.sv
module qrs_thresh_ctrl
    import qrs_pkg::*;
#(
    parameter int MAG_W      = 15,
    parameter int THR_FLOOR  = 900,
    parameter int THR_CEIL   = 1320,
    parameter int DECAY_STEP = 2,
    parameter int NOISE_STEP = 64,
    localparam int EXT_W     = MAG_W + 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_valid,
    input  qrs_phase_e       phase,
    input  logic [MAG_W-1:0] mag,
    input  logic             beat_hit,
    input  logic             noise_hit,
    input  logic             meas_last,
    output logic [MAG_W-1:0] thr
);
    localparam logic [EXT_W-1:0] FLOOR_X = EXT_W'(THR_FLOOR);
    localparam logic [EXT_W-1:0] CEIL_X  = EXT_W'(THR_CEIL);
    localparam logic [EXT_W-1:0] DECAY_X = EXT_W'(DECAY_STEP);
    localparam logic [EXT_W-1:0] NOISE_X = EXT_W'(NOISE_STEP);

    logic [MAG_W-1:0] peak;
    logic [MAG_W-1:0] peak_next;
    logic [EXT_W-1:0] seeded;
    logic [EXT_W-1:0] raised;
    logic [EXT_W-1:0] lowered;
    logic [EXT_W-1:0] thr_x;
    logic             decay_en;

    always_comb begin
        peak_next = (mag > peak) ? mag : peak;
        seeded    = EXT_W'(peak_next) - EXT_W'(peak_next >> 2);
        if (seeded < FLOOR_X)
            seeded = FLOOR_X;
        else if (seeded > CEIL_X)
            seeded = CEIL_X;

        thr_x  = EXT_W'(thr);
        raised = thr_x + NOISE_X;
        if (raised > CEIL_X)
            raised = CEIL_X;

        if (thr_x < FLOOR_X + DECAY_X)
            lowered = FLOOR_X;
        else
            lowered = thr_x - DECAY_X;

        decay_en = smp_valid && (phase != PH_MEAS) && !beat_hit && !noise_hit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            thr  <= FLOOR_X[MAG_W-1:0];
            peak <= '0;
        end else begin
            if (beat_hit)
                peak <= mag;
            else if (smp_valid && phase == PH_MEAS)
                peak <= peak_next;

            if (meas_last)
                thr <= seeded[MAG_W-1:0];
            else if (noise_hit)
                thr <= raised[MAG_W-1:0];
            else if (decay_en)
                thr <= lowered[MAG_W-1:0];
        end
    end

    // R4
    thr_range_chk: assert property (@(posedge clk) disable iff (rst)
        (EXT_W'(thr) >= FLOOR_X) && (EXT_W'(thr) <= CEIL_X));

    // R3
    meas_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_MEAS && !meas_last) |=> $stable(thr));

    // R6
    noise_raise_chk: assert property (@(posedge clk) disable iff (rst)
        noise_hit |=> ((thr > $past(thr)) || (EXT_W'(thr) == CEIL_X)));
endmodule

// File: rtl/qrs_thresh_detector.sv
module qrs_thresh_detector
    import qrs_pkg::*;
#(
    parameter int SAMPLE_W    = 16,
    parameter int SAMPLE_RATE = 500,
    parameter int MEAS_MS     = 200,
    parameter int GUARD_MS    = 240,
    parameter int THR_FLOOR   = 900,
    parameter int THR_CEIL    = 1320,
    parameter int DECAY_STEP  = 2,
    parameter int NOISE_STEP  = 64
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_data,
    output logic                beat_pulse,
    output logic                noise_flag,
    output logic                interval_restart
);
    localparam int MAG_W       = SAMPLE_W - 1;
    localparam int MEAS_TICKS  = int'(ticks_for_ms(SAMPLE_RATE, MEAS_MS));
    localparam int GUARD_TICKS = int'(ticks_for_ms(SAMPLE_RATE, GUARD_MS));

    logic [MAG_W-1:0] mag;
    logic [MAG_W-1:0] thr;
    qrs_phase_e       phase;
    logic             meas_last;
    qrs_event_t       hit;

    qrs_magnitude #(.SAMPLE_W(SAMPLE_W)) u_mag (
        .smp (smp_data),
        .mag (mag)
    );

    always_comb begin
        hit.beat  = smp_valid && (phase == PH_ARMED) && (mag > thr);
        hit.noise = smp_valid && (phase == PH_GUARD) && (mag > thr);
    end

    qrs_window_timer #(
        .MEAS_TICKS  (MEAS_TICKS),
        .GUARD_TICKS (GUARD_TICKS)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .smp_valid (smp_valid),
        .beat_hit  (hit.beat),
        .noise_hit (hit.noise),
        .phase     (phase),
        .meas_last (meas_last)
    );

    qrs_thresh_ctrl #(
        .MAG_W      (MAG_W),
        .THR_FLOOR  (THR_FLOOR),
        .THR_CEIL   (THR_CEIL),
        .DECAY_STEP (DECAY_STEP),
        .NOISE_STEP (NOISE_STEP)
    ) u_thr (
        .clk       (clk),
        .rst       (rst),
        .smp_valid (smp_valid),
        .phase     (phase),
        .mag       (mag),
        .beat_hit  (hit.beat),
        .noise_hit (hit.noise),
        .meas_last (meas_last),
        .thr       (thr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_pulse       <= 1'b0;
            noise_flag       <= 1'b0;
            interval_restart <= 1'b0;
        end else begin
            beat_pulse       <= hit.beat;
            noise_flag       <= hit.noise;
            interval_restart <= hit.noise;
        end
    end

    // R1
    beat_single_chk: assert property (@(posedge clk) disable iff (rst)
        beat_pulse |=> !beat_pulse);

    // R2
    refractory_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_MEAS) |=> !beat_pulse);

    // R5
    noise_excl_chk: assert property (@(posedge clk) disable iff (rst)
        noise_flag |-> !beat_pulse);

    // R7
    most_neg_chk: assert property (@(posedge clk) disable iff (rst)
        (smp_data == {1'b1, {MAG_W{1'b0}}}) |-> (mag == {MAG_W{1'b1}}));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> (!beat_pulse && !noise_flag && !interval_restart));
endmodule

// File: tb/qrs_thresh_detector_bench.sv
module qrs_thresh_detector_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 31;

    // {sample, expected beat, expected noise}; rate 50 -> windows 10 / 12
    localparam logic [17:0] VEC [NVEC] = '{
        {16'd500,   1'b0, 1'b0},  // 0  below floor, decay held at floor
        {16'd900,   1'b0, 1'b0},  // 1  equal to threshold: no beat
        {16'd901,   1'b1, 1'b0},  // 2  beat
        {16'd1200,  1'b0, 1'b0},  // 3  refractory
        {16'hF9C0,  1'b0, 1'b0},  // 4  -1600, peak 1600
        {16'd1500,  1'b0, 1'b0},  // 5  refractory
        {16'd0,     1'b0, 1'b0},
        {16'd0,     1'b0, 1'b0},
        {16'd0,     1'b0, 1'b0},
        {16'd0,     1'b0, 1'b0},
        {16'd0,     1'b0, 1'b0},
        {16'd0,     1'b0, 1'b0},
        {16'd0,     1'b0, 1'b0},  // 12 window end: thr 1200
        {16'd1150,  1'b0, 1'b0},  // 13 guard, decay to 1190
        {16'd1195,  1'b0, 1'b1},  // 14 guard noise, thr 1290
        {16'd1290,  1'b0, 1'b0},  // 15 armed, equal, decay 1280
        {16'd1285,  1'b1, 1'b0},  // 16 beat
        {16'h8000,  1'b0, 1'b0},  // 17 most negative, peak 32767
        {16'd0,     1'b0, 1'b0},
        {16'd0,     1'b0, 1'b0},
        {16'd0,     1'b0, 1'b0},
        {16'd0,     1'b0, 1'b0},
        {16'd0,     1'b0, 1'b0},
        {16'd0,     1'b0, 1'b0},
        {16'd0,     1'b0, 1'b0},
        {16'd0,     1'b0, 1'b0},
        {16'd0,     1'b0, 1'b0},  // 26 window end: clamp to 1320
        {16'd1320,  1'b0, 1'b0},  // 27 guard equal, decay 1310
        {16'd1311,  1'b0, 1'b1},  // 28 noise, raise saturates 1320
        {16'd1320,  1'b0, 1'b0},  // 29 armed equal, decay 1310
        {16'd1315,  1'b1, 1'b0}   // 30 beat
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_data = '0;
    logic        beat_pulse;
    logic        noise_flag;
    logic        interval_restart;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    qrs_thresh_detector #(
        .SAMPLE_W    (16),
        .SAMPLE_RATE (50),
        .MEAS_MS     (200),
        .GUARD_MS    (240),
        .THR_FLOOR   (900),
        .THR_CEIL    (1320),
        .DECAY_STEP  (10),
        .NOISE_STEP  (100)
    ) u_qrs_thresh_detector (
        .clk              (clk),
        .rst              (rst),
        .smp_valid        (smp_valid),
        .smp_data         (smp_data),
        .beat_pulse       (beat_pulse),
        .noise_flag       (noise_flag),
        .interval_restart (interval_restart)
    );

    task automatic check(input logic eb, input logic en, input string tag);
        n_vec++;
        if (beat_pulse !== eb || noise_flag !== en || interval_restart !== en) begin
            n_bad++;
            $display("FAIL %s: beat/noise/restart = %b%b%b expected %b%b%b",
                     tag, beat_pulse, noise_flag, interval_restart, eb, en, en);
        end
    endtask

    // called at a falling edge; drives, waits one cycle, checks
    task automatic apply(input logic [15:0] d, input logic v,
                         input logic eb, input logic en, input string tag);
        smp_data  = d;
        smp_valid = v;
        @(negedge clk);
        check(eb, en, tag);
    endtask

    task automatic do_reset(input string tag);
        rst       = 1'b1;
        smp_valid = 1'b0;
        repeat (2) @(negedge clk);
        check(1'b0, 1'b0, tag);
        rst = 1'b0;
    endtask

    task automatic zeros(input int n, input string tag);
        for (int i = 0; i < n; i++)
            apply(16'd0, 1'b1, 1'b0, 1'b0, tag);
    endtask

    initial begin
        @(negedge clk);
        do_reset("R8 reset state");

        for (int i = 0; i < NVEC; i++)
            apply(VEC[i][17:2], 1'b1, VEC[i][1], VEC[i][0],
                  $sformatf("vector %0d (R1 R2 R3 R4 R5 R6 R7)", i));

        // R8: reset returns threshold to floor
        do_reset("R8 reset clears outputs");
        apply(16'd901, 1'b1, 1'b1, 1'b0, "R8 armed at floor after reset");

        // R3: small peak 901 -> 676 clamps up to floor
        zeros(10, "R2 measurement window");
        zeros(2, "R5 guard quiet");
        apply(16'd900, 1'b1, 1'b0, 1'b0, "R3 floor clamp, equal");
        apply(16'd901, 1'b1, 1'b1, 1'b0, "R3 floor clamp, above");

        // R9: idle cycles with large data neither count nor feed the peak
        for (int i = 0; i < 10; i++) begin
            apply(16'd30000, 1'b0, 1'b0, 1'b0, "R9 idle cycle quiet");
            apply(16'd0, 1'b1, 1'b0, 1'b0, "R9 valid window sample");
        end
        apply(16'd30000, 1'b0, 1'b0, 1'b0, "R9 idle in guard");
        zeros(2, "R9 guard after gapped window");
        apply(16'd900, 1'b1, 1'b0, 1'b0, "R9 peak untouched by idle data");
        apply(16'd901, 1'b1, 1'b1, 1'b0, "R9 beat after gapped window");

        // R4: seed 1760 -> 1320, then decay to the floor and hold it
        apply(16'd1760, 1'b1, 1'b0, 1'b0, "R3 peak sample");
        zeros(9, "R2 measurement window");
        zeros(2, "R4 guard decay");
        zeros(30, "R4 armed decay");
        apply(16'd1000, 1'b1, 1'b0, 1'b0, "R4 equal to decayed 1000");
        apply(16'd991, 1'b1, 1'b1, 1'b0, "R4 above decayed 990");
        zeros(10, "R2 measurement window");
        zeros(2, "R4 guard");
        zeros(60, "R4 long decay");
        apply(16'd900, 1'b1, 1'b0, 1'b0, "R4 floor not undershot");
        apply(16'd901, 1'b1, 1'b1, 1'b0, "R4 beat at floor");

        // R8: reset in the middle of a measurement window
        apply(16'd5000, 1'b1, 1'b0, 1'b0, "R2 refractory before reset");
        do_reset("R8 mid-window reset");
        apply(16'd901, 1'b1, 1'b1, 1'b0, "R8 re-armed after mid-window reset");

        // R7: most negative code as a beat
        zeros(10, "R2 measurement window");
        zeros(2, "R5 guard");
        apply(16'h8000, 1'b1, 1'b1, 1'b0, "R7 0x8000 beat");

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule